// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger Interrupts

This block sits between a word-wide register bus and a byte-serial engine. Software writes transmit bytes into one FIFO, which the serial engine drains, and the engine deposits received bytes into a second FIFO, which software reads. Each direction has its own enable and its own trigger level. The block reports the fill level and the empty and full flags of both FIFOs. It records error conditions in a set of sticky interrupt status bits, and the serial side never stalls.

A trailing-data timer raises an interrupt when the receive FIFO holds some bytes but fewer than the trigger level, and no new byte has arrived for a programmed number of ticks. This lets software collect a short final burst that would never reach the trigger. Every status bit is masked by an enable bit, and the masked bits are merged into one interrupt line. The timer is a three-state machine. In `TR_IDLE` it is disarmed. The transition arm moves it from `TR_IDLE` to `TR_WAIT`, or straight to `TR_HIT` when the limit is zero. In `TR_WAIT` it counts ticks. The transition expire moves it from `TR_WAIT` to `TR_HIT` when the count reaches the limit. `TR_HIT` holds while the timer stays armed. The transition disarm returns it to `TR_IDLE` from any state as soon as the arming condition drops.

Top module: `serial_fifo_irq`

## Requirements
- R1: After reset both FIFOs are disabled and empty, STATUS reads 0x0100_0100, INT_STAT and INT_EN read 0, the trailing limit reads 15, and `irq` is low.
- R2: CTRL (address 0) holds the RX enable at bit 0, the TX enable at bit 1, the RX trigger at bits 10:4 and the TX trigger at bits 16+6:16, and reads back what was written. While its enable is 0, a FIFO is emptied from the next clock on, and pushes, pops and error detection for it are ignored.
- R3: STATUS (address 1) reports the TX level at bits 6:0, TX full at bit 7, TX empty at bit 8, the RX level at bits 22:16, RX full at bit 23 and RX empty at bit 24. A FIFO is full at DEPTH entries.
- R4: Bytes leave each FIFO in the order they entered. `tx_avail` is high exactly when TX is enabled and holds data, and `tx_byte` shows the oldest TX byte. A read of RXDATA (address 5) returns the oldest RX byte and removes it. TXDATA is address 4.
- R5: INT_STAT bit 0 (TX almost-empty) is set at each clock where TX is enabled and the TX level is at or below the TX trigger.
- R6: INT_STAT bit 1 (RX almost-full) is set at each clock where RX is enabled and the RX level is at or above the RX trigger.
- R7: A TXDATA write to a full TX FIFO drops the byte and sets INT_STAT bit 3.
- R8: A `tx_pop` while the TX FIFO is empty sets INT_STAT bit 2 and changes nothing else.
- R9: An `rx_push` into a full RX FIFO drops the byte and sets INT_STAT bit 5.
- R10: An RXDATA read from an empty RX FIFO returns 0 and sets INT_STAT bit 4.
- R11: Trailing timing is defined on an armed condition: RX is enabled, its level is between 1 and the RX trigger minus 1, and no push occurs. The 4-bit limit L is held in TRAIL (address 6). INT_STAT bit 6 is set at the clock that follows 1 + TICK_CYCLES*L consecutive armed clocks. Any unarmed clock restarts the count.
- R12: Writing INT_STAT (address 3) clears exactly the bits written as one. A bit whose set condition holds in the same clock stays set.
- R13: `irq` is the OR of INT_STAT ANDed bitwise with INT_EN (address 2, bits 6:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops RX on RXDATA |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tx_byte | output | 8 | Oldest TX byte (0 when empty) |
| tx_avail | output | 1 | TX enabled and not empty |
| tx_pop | input | 1 | Serial engine takes the TX byte |
| rx_push | input | 1 | Serial engine delivers a byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench builds the block with DEPTH = 16 and TICK_CYCLES = 2. The shallow depth means sixteen writes reach the full boundary, so overrun on both sides, and a push or write on a full FIFO combined with a pop, are cheap to reach. The short tick lets the trailing timer run to its limit within a few dozen clocks, both at the default limit and at small ones. Because the model is compared every clock, it also covers the clocks around disabling a FIFO that still holds data, and a clear that coincides with a set.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    localparam int REG_AW  = 3;
    localparam int NUM_IRQ = 7;
    localparam int FLD_W   = 7;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_IEN   = 3'd2,
        RA_ISTAT = 3'd3,
        RA_TXD   = 3'd4,
        RA_RXD   = 3'd5,
        RA_TRAIL = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    localparam int IB_TXAE  = 0;
    localparam int IB_RXAF  = 1;
    localparam int IB_TXUND = 2;
    localparam int IB_TXOVR = 3;
    localparam int IB_RXUND = 4;
    localparam int IB_RXOVR = 5;
    localparam int IB_TRAIL = 6;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_WAIT = 2'd1,
        TR_HIT  = 2'd2
    } trail_state_e;

endpackage

// File: rtl/sfi_byte_fifo.sv
module sfi_byte_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [7:0]               din,
    input  logic                     pop,
    output logic [7:0]               dout,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     full,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign level   = count;
    assign dout    = empty ? 8'h00 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + LW'(do_push) - LW'(do_pop);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH)); // R3
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(wr_ptr))); // R7
endmodule

// File: rtl/sfi_trail_timer.sv
module sfi_trail_timer
    import sfi_pkg::*;
#(
    parameter int TICK_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic [3:0] limit,
    output logic       fire
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    trail_state_e  state;
    logic [PW-1:0] pre;
    logic [3:0]    ticks;
    logic [4:0]    ticks_inc;

    assign ticks_inc = {1'b0, ticks} + 5'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TR_IDLE;
            pre   <= '0;
            ticks <= '0;
        end else if (!armed) begin
            state <= TR_IDLE;
            pre   <= '0;
            ticks <= '0;
        end else begin
            unique case (state)
                TR_IDLE: begin
                    state <= (limit == 4'd0) ? TR_HIT : TR_WAIT;
                    pre   <= '0;
                    ticks <= '0;
                end
                TR_WAIT: begin
                    if (pre == PW'(TICK_CYCLES - 1)) begin
                        pre   <= '0;
                        ticks <= ticks_inc[3:0];
                        if (ticks_inc >= {1'b0, limit}) state <= TR_HIT;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                TR_HIT: state <= TR_HIT;
                default: state <= TR_IDLE;
            endcase
        end
    end

    always_comb begin
        fire = (state == TR_HIT);
    end

    AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TR_HIT) |-> $past(armed)); // R11
endmodule

// File: rtl/serial_fifo_irq.sv
module serial_fifo_irq
    import sfi_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int TICK_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    reg_addr_e          ra;
    logic               rx_en, tx_en;
    logic [FLD_W-1:0]   rx_trig, tx_trig;
    logic [NUM_IRQ-1:0] ien, istat, iset, iclr;
    logic [3:0]         trail_lim;

    logic [7:0]       rx_dout;
    logic [LW-1:0]    tx_lvl_n, rx_lvl_n;
    logic [FLD_W-1:0] tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_wr, rx_rd, armed, trail_fire;
    logic             unused_wdata;

    assign ra           = reg_addr_e'(bus_addr);
    assign tx_wr        = bus_wr && (ra == RA_TXD);
    assign rx_rd        = bus_rd && (ra == RA_RXD);
    assign tx_lvl       = FLD_W'(tx_lvl_n);
    assign rx_lvl       = FLD_W'(rx_lvl_n);
    assign unused_wdata = ^{bus_wdata[31:23], bus_wdata[15:11], bus_wdata[3:2]};

    sfi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!tx_en),
        .push(tx_wr && tx_en), .din(bus_wdata[7:0]),
        .pop(tx_pop && tx_en), .dout(tx_byte),
        .level(tx_lvl_n), .full(tx_full), .empty(tx_empty)
    );

    sfi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en),
        .push(rx_push && rx_en), .din(rx_byte),
        .pop(rx_rd && rx_en), .dout(rx_dout),
        .level(rx_lvl_n), .full(rx_full), .empty(rx_empty)
    );

    assign armed = rx_en && !rx_empty && (rx_lvl < rx_trig) && !rx_push;

    sfi_trail_timer #(.TICK_CYCLES(TICK_CYCLES)) u_trail (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .limit(trail_lim), .fire(trail_fire)
    );

    always_comb begin
        iset           = '0;
        iset[IB_TXAE]  = tx_en && (tx_lvl <= tx_trig);
        iset[IB_RXAF]  = rx_en && (rx_lvl >= rx_trig);
        iset[IB_TXUND] = tx_en && tx_pop && tx_empty;
        iset[IB_TXOVR] = tx_en && tx_wr && tx_full;
        iset[IB_RXUND] = rx_en && rx_rd && rx_empty;
        iset[IB_RXOVR] = rx_en && rx_push && rx_full;
        iset[IB_TRAIL] = trail_fire;
        iclr = (bus_wr && (ra == RA_ISTAT)) ? bus_wdata[NUM_IRQ-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            tx_en     <= 1'b0;
            rx_trig   <= '0;
            tx_trig   <= '0;
            ien       <= '0;
            istat     <= '0;
            trail_lim <= 4'hF;
        end else begin
            istat <= (istat & ~iclr) | iset;
            if (bus_wr) begin
                unique case (ra)
                    RA_CTRL: begin
                        rx_en   <= bus_wdata[0];
                        tx_en   <= bus_wdata[1];
                        rx_trig <= bus_wdata[10:4];
                        tx_trig <= bus_wdata[22:16];
                    end
                    RA_IEN:   ien       <= bus_wdata[NUM_IRQ-1:0];
                    RA_TRAIL: trail_lim <= bus_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (ra)
            RA_CTRL:  bus_rdata = {9'd0, tx_trig, 5'd0, rx_trig, 2'd0, tx_en, rx_en};
            RA_STAT:  bus_rdata = {7'd0, rx_empty, rx_full, rx_lvl,
                                   7'd0, tx_empty, tx_full, tx_lvl};
            RA_IEN:   bus_rdata = {25'd0, ien};
            RA_ISTAT: bus_rdata = {25'd0, istat};
            RA_RXD:   bus_rdata = {24'd0, rx_en ? rx_dout : 8'h00};
            RA_TRAIL: bus_rdata = {28'd0, trail_lim};
            default:  bus_rdata = '0;
        endcase
    end

    assign tx_avail = tx_en && !tx_empty;
    assign irq      = |(istat & ien);

    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_wr && tx_full) |=> istat[IB_TXOVR]); // R7
    AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_rd && rx_empty) |=> istat[IB_RXUND]); // R10
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty) |-> (bus_rdata == 32'd0)); // R10
    AST_TRAIL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat[IB_TRAIL]) |-> $past(trail_fire)); // R11
    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_push && rx_full) |=> istat[IB_RXOVR]); // R9
endmodule

// File: tb/serial_fifo_irq_test.sv
module serial_fifo_irq_test;
    localparam int DEPTH = 16;
    localparam int TICK  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_pop = 1'b0, rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        irq;

    always #4 clk = ~clk;

    serial_fifo_irq #(.DEPTH(DEPTH), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .irq(irq)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    bit       m_rx_en, m_tx_en;
    int       m_rx_trig, m_tx_trig, m_lim, run;
    bit [6:0] m_ien, m_stat;
    byte unsigned txq[$], rxq[$];

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(int a);
        int tl = txq.size(), rl = rxq.size();
        case (a)
            0: return (m_tx_trig << 16) | (m_rx_trig << 4) | (m_tx_en << 1) | m_rx_en;
            1: return tl | ((tl == DEPTH) << 7) | ((tl == 0) << 8) |
                      (rl << 16) | ((rl == DEPTH) << 23) | ((rl == 0) << 24);
            2: return 32'(m_ien);
            3: return 32'(m_stat);
            5: return (m_rx_en && rl > 0) ? 32'(rxq[0]) : 32'd0;
            6: return 32'(m_lim);
            default: return 32'd0;
        endcase
    endfunction

    task automatic step();
        int tl, rl;
        bit [6:0] set, clr;
        bit arm;
        #1;
        chk("R13 irq", 32'(irq), 32'(|(m_stat & m_ien)));
        chk("R4 tx_avail", 32'(tx_avail), 32'(m_tx_en && txq.size() > 0));
        if (tx_avail && txq.size() > 0) chk("R4 tx_byte", 32'(tx_byte), 32'(txq[0]));
        if (bus_rd) chk(tag, bus_rdata, exp_rd(int'(bus_addr)));
        tl = txq.size(); rl = rxq.size();
        set[0] = m_tx_en && tl <= m_tx_trig;
        set[1] = m_rx_en && rl >= m_rx_trig;
        set[2] = m_tx_en && tx_pop && tl == 0;
        set[3] = m_tx_en && bus_wr && bus_addr == 4 && tl == DEPTH;
        set[4] = m_rx_en && bus_rd && bus_addr == 5 && rl == 0;
        set[5] = m_rx_en && rx_push && rl == DEPTH;
        set[6] = run >= 1 + TICK * m_lim;
        arm = m_rx_en && rl > 0 && rl < m_rx_trig && !rx_push;
        run = arm ? ((run < 1000) ? run + 1 : run) : 0;
        if (m_tx_en) begin
            if (tx_pop && tl > 0) void'(txq.pop_front());
            if (bus_wr && bus_addr == 4 && tl < DEPTH) txq.push_back(bus_wdata[7:0]);
        end else txq.delete();
        if (m_rx_en) begin
            if (bus_rd && bus_addr == 5 && rl > 0) void'(rxq.pop_front());
            if (rx_push && rl < DEPTH) rxq.push_back(rx_byte);
        end else rxq.delete();
        clr = (bus_wr && bus_addr == 3) ? bus_wdata[6:0] : 7'd0;
        m_stat = (m_stat & ~clr) | set;
        if (bus_wr && bus_addr == 0) begin
            m_rx_en = bus_wdata[0]; m_tx_en = bus_wdata[1];
            m_rx_trig = int'(bus_wdata[10:4]); m_tx_trig = int'(bus_wdata[22:16]);
        end
        if (bus_wr && bus_addr == 2) m_ien = bus_wdata[6:0];
        if (bus_wr && bus_addr == 6) m_lim = int'(bus_wdata[3:0]);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = d; step();
    endtask
    task automatic rd(int a, string t);
        tag = t; bus_rd = 1; bus_addr = 3'(a); step();
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_lim = 15; run = 0; m_ien = 0; m_stat = 0;
        m_rx_en = 0; m_tx_en = 0; m_rx_trig = 0; m_tx_trig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        rd(1, "R1 status"); rd(3, "R1 istat"); rd(6, "R1 trail"); rd(2, "R1 ien");
        // R2: control layout and readback
        wr(0, 32'h0002_0043); rd(0, "R2 ctrl");
        wr(2, 32'h7F);
        // R5 / R4: tx almost-empty and ordering
        idle(2); rd(3, "R5 istat");
        for (int i = 0; i < 4; i++) wr(4, 32'(8'hA0 + i));
        wr(3, 32'h7F); rd(3, "R5 cleared"); rd(1, "R3 status");
        for (int i = 0; i < 4; i++) begin tx_pop = 1; step(); end
        // R8: pop on empty
        tx_pop = 1; step(); rd(3, "R8 istat");
        // R7: overrun at depth
        for (int i = 0; i < DEPTH; i++) wr(4, 32'(i * 3));
        rd(1, "R3 tx full"); wr(4, 32'hEE); rd(3, "R7 istat");
        tx_pop = 1; bus_wr = 1; bus_addr = 4; bus_wdata = 32'h55; step();
        rd(1, "R7 pop+write");
        // R12: clear while almost-empty holds
        for (int i = 0; i < DEPTH; i++) begin tx_pop = 1; step(); end
        wr(3, 32'h7F); rd(3, "R12 set wins");
        // R6 / R11: rx side
        wr(6, 32'd3); rd(6, "R11 trail");
        rx_byte = 8'h11; rx_push = 1; step();
        rx_byte = 8'h22; rx_push = 1; step();
        wr(3, 32'h7F);
        idle(10); rd(3, "R11 trailing");
        wr(6, 32'd0); wr(3, 32'h7F); idle(2); rd(3, "R11 limit0");
        rd(5, "R4 rx first"); rd(5, "R4 rx second");
        rd(5, "R10 empty read"); rd(3, "R10 istat");
        for (int i = 0; i < DEPTH + 1; i++) begin rx_byte = 8'(i + 7); rx_push = 1; step(); end
        rd(1, "R3 rx full"); rd(3, "R9 istat"); rd(3, "R6 istat");
        rx_push = 1; rx_byte = 8'h99; bus_rd = 1; bus_addr = 5; tag = "R9 push+read"; step();
        // R13: mask subsets
        wr(2, 32'h20); wr(3, 32'h20); idle(1); wr(2, 32'h08); idle(1);
        // R2: disable flushes and ignores traffic
        wr(0, 32'h0002_0041); rd(1, "R2 pre-flush"); rd(1, "R2 flushed");
        wr(4, 32'h12); tx_pop = 1; step(); rd(1, "R2 ignored"); rd(3, "R2 istat");
        wr(0, 32'h0); rx_push = 1; step(); rd(5, "R2 rx off"); rd(1, "R2 both off");
        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule